// File: doc/BRIEF.md
# Context Interrupt Winner Selector

This block picks, for one interrupt target context, the single source that should be presented to that context right now. Every source has three bits: whether it is pending, whether this context has enabled it, and whether a handler has already claimed it. Every source also carries a 3-bit priority. The context supplies a threshold. Among the sources that are pending, enabled and not claimed, the block finds the one with the highest priority above the threshold. It reports that source's ID and raises a level request toward the context.

The bit vectors are flat and grouped into 32-bit words. The source count is a parameter, so the vector width is that count rounded up to whole words. The selection is a balanced reduction tree of (valid, priority, ID) triples. The result is registered once, so a change on any input shows up at the outputs on the next clock. One instance is placed per context. The register interface, the gateway logic and the mapping of contexts to harts sit around the block and are not part of it.

Top module: `ctx_irq_select`

## Requirements
- R1: A source is a candidate only when its pending bit is 1, its enable bit is 1 and its claimed bit is 0. When no source is a candidate, the selected ID is 0.
- R2: A candidate can win only if its priority is strictly greater than `thr_i`. A priority equal to the threshold never wins.
- R3: The candidate with the highest priority wins. Among candidates of equal priority, the one with the lowest ID wins, including across a 32-bit word boundary.
- R4: ID 0 means "no source". Bit 0 of the vectors is never selected, whatever its pending bit, enable bit and priority.
- R5: `irq_o` is 1 exactly when `win_id_o` is nonzero.
- R6: Source n sits at bit n of `pend_i`, `en_i` and `claimed_i`, which is word n/32, bit n mod 32. Its priority sits at `prio_i[3n+2:3n]`. Bits of sources n >= NUM_SRC are ignored.
- R7: The outputs are registered. A change on the inputs reaches `win_id_o` and `irq_o` after the next rising clock edge and not before it.
- R8: While `rst_n` is low, `win_id_o` is 0 and `irq_o` is 0.
- R9: A source with priority 0 never wins, even with a threshold of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | BITS | Pending bit for each source (BITS = 32 * ceil(NUM_SRC/32)) |
| en_i | input | BITS | Enable bit for each source, for this context |
| claimed_i | input | BITS | Claimed bit for each source |
| prio_i | input | 3*BITS | 3-bit priority for each source, packed |
| thr_i | input | 3 | Context threshold |
| win_id_o | output | clog2(BITS) | Registered ID of the winning source, 0 when there is none |
| irq_o | output | 1 | Registered interrupt request level for the context |

## Verification
The bench builds the block with NUM_SRC = 40. This makes the vectors two words wide (64 bits) and leaves sources 40 to 63 as padding. That choice makes two cases reachable: a tie that straddles the word boundary at sources 31 and 32, and a pending padding bit with top priority that must lose to real source 39. The tree then has 64 leaves, so the padding logic and six tree levels are exercised. A reference scoreboard scans sources in ascending order, and random vectors are compared against it.

// File: rtl/ctx_sel_pkg.sv
package ctx_sel_pkg;
   localparam int PRIO_W = 3;
   localparam int WORD_W = 32;

   // Right-hand (higher ID) entry replaces the left only on strictly higher priority.
   function automatic logic take_hi(input logic lo_v, input logic [PRIO_W-1:0] lo_p,
                                    input logic hi_v, input logic [PRIO_W-1:0] hi_p);
      return hi_v && (!lo_v || (hi_p > lo_p));
   endfunction
endpackage

// File: rtl/ctx_sel_mask.sv
module ctx_sel_mask
   import ctx_sel_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int WORDS   = (NUM_SRC + WORD_W - 1) / WORD_W,
   localparam int BITS   = WORDS * WORD_W
) (
   input  logic [BITS-1:0]        pend_i,
   input  logic [BITS-1:0]        en_i,
   input  logic [BITS-1:0]        claimed_i,
   input  logic [BITS*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]      thr_i,
   output logic [BITS-1:0]        cand_o
);
   function automatic logic [BITS-1:0] live_map();
      logic [BITS-1:0] m;
      for (int n = 0; n < BITS; n++) m[n] = (n != 0) && (n < NUM_SRC);
      return m;
   endfunction

   localparam logic [BITS-1:0] LIVE = live_map();

   logic [BITS-1:0] raw;
   logic [BITS-1:0] above;

   assign raw = pend_i & en_i & ~claimed_i;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < WORD_W; b++) begin : g_bit
         localparam int N = w * WORD_W + b;
         assign above[N] = prio_i[N*PRIO_W +: PRIO_W] > thr_i;
      end
   end

   assign cand_o = raw & above & LIVE;
endmodule

// File: rtl/ctx_sel_tree.sv
module ctx_sel_tree
   import ctx_sel_pkg::*;
#(
   parameter int BITS    = 64,
   localparam int LEAVES = 1 << $clog2(BITS),
   localparam int ID_W   = $clog2(BITS)
) (
   input  logic [BITS-1:0]        cand_i,
   input  logic [BITS*PRIO_W-1:0] prio_i,
   output logic                   best_v_o,
   output logic [ID_W-1:0]        best_id_o
);
   logic              nv [2*LEAVES];
   logic [PRIO_W-1:0] np [2*LEAVES];
   logic [ID_W-1:0]   ni [2*LEAVES];

   assign nv[0] = 1'b0;
   assign np[0] = '0;
   assign ni[0] = '0;

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < BITS) begin : g_real
         assign nv[LEAVES+i] = cand_i[i];
         assign np[LEAVES+i] = prio_i[i*PRIO_W +: PRIO_W];
         assign ni[LEAVES+i] = ID_W'(i);
      end else begin : g_pad
         assign nv[LEAVES+i] = 1'b0;
         assign np[LEAVES+i] = '0;
         assign ni[LEAVES+i] = '0;
      end
   end

   // Node k merges 2k (lower IDs) and 2k+1 (higher IDs).
   for (genvar k = 1; k < LEAVES; k++) begin : g_node
      logic hi_sel;
      assign hi_sel = take_hi(nv[2*k], np[2*k], nv[2*k+1], np[2*k+1]);
      assign nv[k]  = nv[2*k] | nv[2*k+1];
      assign np[k]  = hi_sel ? np[2*k+1] : np[2*k];
      assign ni[k]  = hi_sel ? ni[2*k+1] : ni[2*k];
   end

   assign best_v_o  = nv[1];
   assign best_id_o = ni[1];
endmodule

// File: rtl/ctx_irq_select.sv
module ctx_irq_select
   import ctx_sel_pkg::*;
#(
   parameter int NUM_SRC = 64,
   localparam int WORDS  = (NUM_SRC + WORD_W - 1) / WORD_W,
   localparam int BITS   = WORDS * WORD_W,
   localparam int ID_W   = $clog2(BITS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [BITS-1:0]        pend_i,
   input  logic [BITS-1:0]        en_i,
   input  logic [BITS-1:0]        claimed_i,
   input  logic [BITS*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]      thr_i,
   output logic [ID_W-1:0]        win_id_o,
   output logic                   irq_o
);
   if (NUM_SRC < 2)    $error("NUM_SRC must be at least 2");
   if (NUM_SRC > 1024) $error("NUM_SRC above 1024 not supported");

   logic [BITS-1:0] cand;
   logic            best_v;
   logic [ID_W-1:0] best_id;

   ctx_sel_mask #(.NUM_SRC(NUM_SRC), .WORDS(WORDS)) u_mask (
      .pend_i    (pend_i),
      .en_i      (en_i),
      .claimed_i (claimed_i),
      .prio_i    (prio_i),
      .thr_i     (thr_i),
      .cand_o    (cand)
   );

   ctx_sel_tree #(.BITS(BITS)) u_tree (
      .cand_i    (cand),
      .prio_i    (prio_i),
      .best_v_o  (best_v),
      .best_id_o (best_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_id_o <= '0;
         irq_o    <= 1'b0;
      end else begin
         win_id_o <= best_v ? best_id : '0;
         irq_o    <= best_v;
      end
   end
endmodule

// File: rtl/ctx_irq_select_chk.sv
module ctx_irq_select_chk
   import ctx_sel_pkg::*;
#(
   parameter int NUM_SRC = 64,
   localparam int WORDS  = (NUM_SRC + WORD_W - 1) / WORD_W,
   localparam int BITS   = WORDS * WORD_W,
   localparam int ID_W   = $clog2(BITS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [BITS-1:0]        pend_i,
   input  logic [BITS-1:0]        en_i,
   input  logic [BITS-1:0]        claimed_i,
   input  logic [BITS*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]      thr_i,
   input  logic [ID_W-1:0]        win_id_o,
   input  logic                   irq_o
);
   logic                   seen;
   logic [BITS-1:0]        pend_q, en_q, clm_q;
   logic [BITS*PRIO_W-1:0] prio_q;
   logic [PRIO_W-1:0]      thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= 1'b0; pend_q <= '0; en_q <= '0; clm_q <= '0; prio_q <= '0; thr_q <= '0;
      end else begin
         seen <= 1'b1; pend_q <= pend_i; en_q <= en_i; clm_q <= claimed_i;
         prio_q <= prio_i; thr_q <= thr_i;
      end
   end

   p_win_is_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && win_id_o != 0) |-> (pend_q[win_id_o] && en_q[win_id_o] && !clm_q[win_id_o]));

   p_none_when_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && ((pend_q & en_q & ~clm_q) == '0)) |-> (win_id_o == 0));

   p_above_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && win_id_o != 0) |-> (prio_q[int'(win_id_o)*PRIO_W +: PRIO_W] > thr_q));

   p_live_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_id_o != 0) |-> (int'(win_id_o) < NUM_SRC));

   p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (win_id_o != 0));

   p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (win_id_o == 0 && !irq_o));
endmodule

bind ctx_irq_select ctx_irq_select_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/sim_ctx_irq_select.sv
module sim_ctx_irq_select;
   localparam int NSRC = 40;
   localparam int BITS = 64;
   localparam int IDW  = 6;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [BITS-1:0]   pend, en, clm;
   logic [BITS*3-1:0] prio;
   logic [2:0]        thr;
   logic [IDW-1:0]    win_id;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   ctx_irq_select #(.NUM_SRC(NSRC)) u0 (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .claimed_i(clm),
      .prio_i(prio), .thr_i(thr), .win_id_o(win_id), .irq_o(irq));

   typedef struct packed {
      logic [63:0] p;
      logic [63:0] e;
      logic [63:0] c;
      logic [2:0]  t;
      logic [2:0]  base;
      logic [7:0]  hot;
      logic [2:0]  hotp;
      logic [7:0]  exp;
   } vec_t;

   localparam logic [63:0] ALL = '1;
   localparam vec_t TBL [12] = '{
      '{64'h208,        ALL,    64'h0,   3'd0, 3'd2, 8'd9,  3'd5, 8'd9 },
      '{64'h208,        ALL,    64'h0,   3'd0, 3'd2, 8'd9,  3'd2, 8'd3 },
      '{64'h208,        64'h200, 64'h0,  3'd0, 3'd2, 8'd9,  3'd1, 8'd9 },
      '{64'h208,        ALL,    64'h200, 3'd0, 3'd2, 8'd9,  3'd7, 8'd3 },
      '{64'h200,        ALL,    64'h0,   3'd2, 3'd2, 8'd9,  3'd2, 8'd0 },
      '{64'h200,        ALL,    64'h0,   3'd2, 3'd2, 8'd9,  3'd3, 8'd9 },
      '{64'h1_8000_0000, ALL,   64'h0,   3'd3, 3'd4, 8'd32, 3'd4, 8'd31},
      '{64'h1_8000_0000, ALL,   64'h0,   3'd3, 3'd4, 8'd32, 3'd5, 8'd32},
      '{64'h1,          ALL,    64'h0,   3'd0, 3'd7, 8'd0,  3'd7, 8'd0 },
      '{64'h2080_0000_0000, ALL, 64'h0,  3'd0, 3'd1, 8'd45, 3'd7, 8'd39},
      '{ALL,            ALL,    64'h0,   3'd0, 3'd0, 8'd20, 3'd1, 8'd20},
      '{ALL,            ALL,    64'h0,   3'd0, 3'd0, 8'd20, 3'd0, 8'd0 }
   };

   function automatic logic [IDW-1:0] ref_sel(input logic [63:0] p, e, c,
                                              input logic [191:0] pr, input logic [2:0] t);
      logic [IDW-1:0] best = '0;
      logic [2:0]     bp   = t;
      for (int i = 1; i < NSRC; i++)
         if (p[i] && e[i] && !c[i] && pr[i*3 +: 3] > bp) begin
            best = IDW'(i);
            bp   = pr[i*3 +: 3];
         end
      return best;
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic load(input vec_t v);
      pend = v.p; en = v.e; clm = v.c; thr = v.t;
      for (int i = 0; i < BITS; i++) prio[i*3 +: 3] = v.base;
      prio[int'(v.hot)*3 +: 3] = v.hotp;
   endtask

   initial begin
      for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; pend = ALL; en = ALL; clm = '0; thr = '0; prio = '1;
      repeat (3) @(negedge clk);
      chk("R8 reset id", int'(win_id), 0);
      chk("R8 reset irq", int'(irq), 0);
      rst_n = 1'b1;

      // table walk: hand-computed result plus scoreboard cross-check
      for (int k = 0; k < 12; k++) begin
         load(TBL[k]);
         @(negedge clk);
         chk($sformatf("R1/R2/R3/R4/R6/R9 row %0d", k), int'(win_id), int'(TBL[k].exp));
         chk($sformatf("R5 row %0d irq", k), int'(irq), int'(TBL[k].exp != 0));
         chk($sformatf("R3 row %0d scoreboard", k), int'(win_id),
             int'(ref_sel(pend, en, clm, prio, thr)));
      end

      // R7: output holds until the next rising edge
      load(TBL[11]);
      @(negedge clk);
      load(TBL[0]);
      #1 chk("R7 no change before edge", int'(win_id), 0);
      @(negedge clk);
      chk("R7 change after one edge", int'(win_id), 9);

      // R8: reset mid-run clears the outputs
      rst_n = 1'b0;
      #1 chk("R8 async clear id", int'(win_id), 0);
      chk("R8 async clear irq", int'(irq), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // random vectors against the scoreboard
      for (int n = 0; n < 400; n++) begin
         logic [IDW-1:0] e;
         pend = {$urandom, $urandom} & {$urandom, $urandom};
         en   = {$urandom, $urandom} | {$urandom, $urandom};
         clm  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         for (int i = 0; i < BITS; i++) prio[i*3 +: 3] = 3'($urandom);
         thr  = 3'($urandom % 5);
         e    = ref_sel(pend, en, clm, prio, thr);
         @(negedge clk);
         chk("R1/R2/R3 random", int'(win_id), int'(e));
         chk("R5 random irq", int'(irq), int'(e != 0));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule